// File: doc/BRIEF.md
# Dual-Port Pointer Generator with Circular Buffers

This block keeps a bank of eight 16-bit pointer registers that serve as operand addresses for indirect memory access. Two address units work side by side: each picks a pointer, presents its current value as an address, and writes a modified value back on the next clock edge. So two operand addresses are produced, and both pointers advanced, in every cycle.

Each unit can hold a pointer, step it by one in either direction, or add or subtract a 16-bit constant. Two circular buffers, each with its own first and last address, can be bound to any pointer through a control register. A pointer bound to an enabled buffer wraps inside that buffer, so filter and correlation loops can walk a delay line with no address checks in software. A single write port loads pointers, buffer bounds and the control register.

Top module: `agu_circ`

## Requirements
- R1: After reset every pointer, every buffer bound and the control register are zero.
- R2: A write with `wr_en` high stores `wr_data` at the next rising edge into the target chosen by `wr_sel`: codes 0 to 7 select a pointer, 8 and 9 the first and last address of buffer 0, 10 and 11 those of buffer 1, and 12 the control register.
- R3: Each `u_addr` shows the selected pointer's value before modification. The modified value is stored at the next rising edge.
- R4: Operation codes are 0 hold, 1 add one, 2 subtract one, 3 add `u_imm`, 4 subtract `u_imm`. Codes 5 to 7 hold. Linear results wrap modulo 2^16.
- R5: The two units update two different pointers in the same cycle, and each gets its own result.
- R6: When both units update the same pointer in one cycle, the result of unit 0 is stored.
- R7: A write to a pointer through the write port overrides both unit results for that pointer.
- R8: Control bit 0 enables buffer 0 and bits 3:1 give its pointer index. Bit 4 enables buffer 1 and bits 7:5 give its pointer index. For a bound pointer inside its buffer, stepping past the last address continues at the first address, and stepping below the first address continues at the last address.
- R9: In circular mode the step is reduced modulo the buffer length, last − first + 1.
- R10: A pointer that is not bound to an enabled buffer moves linearly. If both enabled buffers are bound to the same pointer, buffer 0 applies.
- R11: A pointer outside its buffer, or bound to a buffer whose last address is below its first, moves linearly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| u_op | input | NUM_UNITS x 3 | Operation code for each unit |
| u_sel | input | NUM_UNITS x 3 | Pointer index for each unit |
| u_imm | input | NUM_UNITS x AW | Constant step for each unit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register write target |
| wr_data | input | AW | Register write value |
| u_addr | output | NUM_UNITS x AW | Unmodified pointer value for each unit |

## Verification
Three things can land on one pointer in the same cycle: an update from unit 0, an update from unit 1, and a load through the write port. The bench aims both units at one pointer, with and without a load to that pointer, and reads the stored value back to find out which source won. It also runs both units on two different circular buffers at once, each wrapping at its own edge, and checks that the two results stay apart.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_INC  = 3'd1,
        OP_DEC  = 3'd2,
        OP_ADDK = 3'd3,
        OP_SUBK = 3'd4
    } agu_op_e;

endpackage

// File: rtl/agu_arith.sv
module agu_arith
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int NP = 8,
    parameter int NB = 2,
    localparam int IW = $clog2(NP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             op,
    input  logic [IW-1:0]          sel,
    input  logic [AW-1:0]          imm,
    input  logic [AW-1:0]          cur,
    input  logic [NB-1:0][AW-1:0]  bstart,
    input  logic [NB-1:0][AW-1:0]  bend,
    input  logic [NB-1:0]          ben,
    input  logic [NB-1:0][IW-1:0]  bidx,
    output logic [AW-1:0]          nxt,
    output logic                   upd
);

    logic [AW-1:0] step;
    logic          up;
    logic          hit;
    logic [AW-1:0] s_start;
    logic [AW-1:0] s_end;
    logic          circ;
    logic [AW:0]   len_w;
    logic [AW:0]   div_w;
    logic [AW:0]   step_m;
    logic [AW:0]   off;
    logic [AW:0]   sum;
    logic [AW-1:0] circ_val;
    logic [AW-1:0] lin_val;

    always_comb begin
        upd  = (op == OP_INC) || (op == OP_DEC) || (op == OP_ADDK) || (op == OP_SUBK);
        up   = (op == OP_INC) || (op == OP_ADDK);
        step = ((op == OP_INC) || (op == OP_DEC)) ? AW'(1) : imm;

        // buffer search runs downward so the lowest-numbered buffer wins
        hit     = 1'b0;
        s_start = '0;
        s_end   = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (ben[b] && (bidx[b] == sel)) begin
                hit     = 1'b1;
                s_start = bstart[b];
                s_end   = bend[b];
            end
        end

        circ   = hit && (s_end >= s_start) && (cur >= s_start) && (cur <= s_end);
        len_w  = {1'b0, s_end} - {1'b0, s_start} + (AW+1)'(1);
        div_w  = circ ? len_w : (AW+1)'(1);
        step_m = {1'b0, step} % div_w;
        off    = {1'b0, cur - s_start};

        if (up) begin
            sum = off + step_m;
            if (sum >= len_w) begin
                sum = sum - len_w;
            end
        end else if (off >= step_m) begin
            sum = off - step_m;
        end else begin
            sum = off + len_w - step_m;
        end

        circ_val = s_start + sum[AW-1:0];
        lin_val  = up ? (cur + step) : (cur - step);
        nxt      = circ ? circ_val : lin_val;
    end

    AST_CIRC_STAYS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && circ) |-> ((nxt >= s_start) && (nxt <= s_end))); // R8

    AST_LINEAR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_INC) && !hit) |-> (nxt == cur + AW'(1))); // R10

endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
    parameter int AW = 16,
    parameter int NP = 8,
    parameter int NB = 2,
    parameter int NU = 2,
    localparam int IW  = $clog2(NP),
    localparam int RSW = $clog2(NP + 2*NB + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RSW-1:0]         wr_sel,
    input  logic [AW-1:0]          wr_data,
    input  logic [NU-1:0]          upd,
    input  logic [NU-1:0][IW-1:0]  upd_sel,
    input  logic [NU-1:0][AW-1:0]  upd_val,
    output logic [NP-1:0][AW-1:0]  ptr,
    output logic [NB-1:0][AW-1:0]  bstart,
    output logic [NB-1:0][AW-1:0]  bend,
    output logic [NB-1:0]          ben,
    output logic [NB-1:0][IW-1:0]  bidx
);

    localparam int CTL_CODE = NP + 2*NB;
    localparam int FW       = IW + 1;

    typedef struct packed {
        logic [NP-1:0][AW-1:0] ptr;
        logic [NB-1:0][AW-1:0] bstart;
        logic [NB-1:0][AW-1:0] bend;
        logic [NB-1:0]         ben;
        logic [NB-1:0][IW-1:0] bidx;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // higher units first so unit 0 is applied last and wins
        for (int u = NU - 1; u >= 0; u--) begin
            if (upd[u]) begin
                st_d.ptr[upd_sel[u]] = upd_val[u];
            end
        end
        if (wr_en) begin
            for (int p = 0; p < NP; p++) begin
                if (wr_sel == RSW'(p)) st_d.ptr[p] = wr_data;
            end
            for (int b = 0; b < NB; b++) begin
                if (wr_sel == RSW'(NP + 2*b))     st_d.bstart[b] = wr_data;
                if (wr_sel == RSW'(NP + 2*b + 1)) st_d.bend[b]   = wr_data;
            end
            if (wr_sel == RSW'(CTL_CODE)) begin
                for (int b = 0; b < NB; b++) begin
                    st_d.ben[b]  = wr_data[b*FW];
                    st_d.bidx[b] = wr_data[b*FW+1 +: IW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr    = st_q.ptr;
    assign bstart = st_q.bstart;
    assign bend   = st_q.bend;
    assign ben    = st_q.ben;
    assign bidx   = st_q.bidx;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel < RSW'(NP))) |=>
            (st_q.ptr[$past(wr_sel[IW-1:0])] == $past(wr_data))); // R7

    AST_UNIT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd[0] && !(wr_en && (wr_sel == RSW'(upd_sel[0])))) |=>
            (st_q.ptr[$past(upd_sel[0])] == $past(upd_val[0]))); // R6

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (upd == '0)) |=> $stable(st_q.ptr)); // R4

endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
    parameter int AW        = 16,
    parameter int NUM_PTR   = 8,
    parameter int NUM_BUF   = 2,
    parameter int NUM_UNITS = 2,
    localparam int IW  = $clog2(NUM_PTR),
    localparam int RSW = $clog2(NUM_PTR + 2*NUM_BUF + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_UNITS-1:0][2:0]     u_op,
    input  logic [NUM_UNITS-1:0][IW-1:0]  u_sel,
    input  logic [NUM_UNITS-1:0][AW-1:0]  u_imm,
    input  logic                          wr_en,
    input  logic [RSW-1:0]                wr_sel,
    input  logic [AW-1:0]                 wr_data,
    output logic [NUM_UNITS-1:0][AW-1:0]  u_addr
);

    logic [NUM_PTR-1:0][AW-1:0]  ptr;
    logic [NUM_BUF-1:0][AW-1:0]  bstart;
    logic [NUM_BUF-1:0][AW-1:0]  bend;
    logic [NUM_BUF-1:0]          ben;
    logic [NUM_BUF-1:0][IW-1:0]  bidx;
    logic [NUM_UNITS-1:0]        upd;
    logic [NUM_UNITS-1:0][AW-1:0] upd_val;

    agu_regfile #(.AW(AW), .NP(NUM_PTR), .NB(NUM_BUF), .NU(NUM_UNITS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd     (upd),
        .upd_sel (u_sel),
        .upd_val (upd_val),
        .ptr     (ptr),
        .bstart  (bstart),
        .bend    (bend),
        .ben     (ben),
        .bidx    (bidx)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        assign u_addr[g] = ptr[u_sel[g]];

        agu_arith #(.AW(AW), .NP(NUM_PTR), .NB(NUM_BUF)) u_arith (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (u_op[g]),
            .sel    (u_sel[g]),
            .imm    (u_imm[g]),
            .cur    (ptr[u_sel[g]]),
            .bstart (bstart),
            .bend   (bend),
            .ben    (ben),
            .bidx   (bidx),
            .nxt    (upd_val[g]),
            .upd    (upd[g])
        );
    end

endmodule

// File: tb/agu_circ_tb.sv
module agu_circ_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0][2:0]   u_op = '0;
    logic [1:0][2:0]   u_sel = '0;
    logic [1:0][15:0]  u_imm = '0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_sel = '0;
    logic [15:0]       wr_data = '0;
    logic [1:0][15:0]  u_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    agu_circ u_dut (
        .clk(clk), .rst_n(rst_n), .u_op(u_op), .u_sel(u_sel), .u_imm(u_imm),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .u_addr(u_addr)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] s, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(int p, output logic [15:0] v);
        @(negedge clk);
        u_op = '0; u_sel[0] = 3'(p);
        #1 v = u_addr[0];
    endtask

    task automatic go(logic [2:0] o0, int s0, logic [15:0] k0,
                      logic [2:0] o1, int s1, logic [15:0] k1,
                      logic we, logic [3:0] ws, logic [15:0] wd,
                      output logic [15:0] a0, output logic [15:0] a1);
        @(negedge clk);
        u_op[0] = o0; u_sel[0] = 3'(s0); u_imm[0] = k0;
        u_op[1] = o1; u_sel[1] = 3'(s1); u_imm[1] = k1;
        wr_en = we; wr_sel = ws; wr_data = wd;
        #1 a0 = u_addr[0]; a1 = u_addr[1];
        @(posedge clk); #1;
        u_op = '0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int p = 0; p < 8; p++) begin
            rd(p, v); check("R1 pointer reset", v, 16'h0);
        end
    endtask

    task automatic t_write();
        logic [15:0] v;
        for (int p = 0; p < 8; p++) wr(4'(p), 16'h1000 + 16'(p * 16'h11));
        for (int p = 0; p < 8; p++) begin
            rd(p, v); check("R2 pointer write", v, 16'h1000 + 16'(p * 16'h11));
        end
    endtask

    task automatic t_ops();
        logic [15:0] a0, a1, v;
        wr(4'd2, 16'h0050);
        go(3'd1, 2, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        check("R3 address before change", a0, 16'h0050);
        rd(2, v); check("R4 inc", v, 16'h0051);
        go(3'd2, 2, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        check("R3 address before dec", a0, 16'h0051);
        rd(2, v); check("R4 dec", v, 16'h0050);
        go(3'd3, 2, 16'h20, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(2, v); check("R4 add constant", v, 16'h0070);
        go(3'd4, 2, 16'h80, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(2, v); check("R4 subtract constant wraps 2^16", v, 16'hFFF0);
        go(3'd5, 2, 16'h5, 3'd7, 2, 16'h5, 0, 0, 0, a0, a1);
        rd(2, v); check("R4 unused codes hold", v, 16'hFFF0);
    endtask

    task automatic t_dual();
        logic [15:0] a0, a1, v;
        wr(4'd0, 16'h0010); wr(4'd1, 16'h0020);
        go(3'd1, 0, 0, 3'd3, 1, 16'h5, 0, 0, 0, a0, a1);
        check("R5 unit0 address", a0, 16'h0010);
        check("R5 unit1 address", a1, 16'h0020);
        rd(0, v); check("R5 unit0 result", v, 16'h0011);
        rd(1, v); check("R5 unit1 result", v, 16'h0025);
    endtask

    task automatic t_conflict();
        logic [15:0] a0, a1, v;
        wr(4'd4, 16'h0040);
        go(3'd1, 4, 0, 3'd3, 4, 16'h100, 0, 0, 0, a0, a1);
        rd(4, v); check("R6 unit0 wins", v, 16'h0041);
        go(3'd1, 4, 0, 3'd2, 4, 0, 1, 4'd4, 16'h1234, a0, a1);
        rd(4, v); check("R7 write wins", v, 16'h1234);
    endtask

    task automatic t_circ();
        logic [15:0] a0, a1, v;
        wr(4'd8, 16'h0100); wr(4'd9, 16'h0103);
        wr(4'd12, 16'h0007);
        wr(4'd3, 16'h0102);
        go(3'd1, 3, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R8 inc inside buffer", v, 16'h0103);
        go(3'd1, 3, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        check("R8 address at last", a0, 16'h0103);
        rd(3, v); check("R8 wrap to first", v, 16'h0100);
        go(3'd2, 3, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R8 wrap to last", v, 16'h0103);
        wr(4'd10, 16'h0200); wr(4'd11, 16'h0204);
        wr(4'd12, 16'h00B7);
        wr(4'd5, 16'h0204);
        go(3'd1, 3, 0, 3'd3, 5, 16'h1, 0, 0, 0, a0, a1);
        rd(3, v); check("R8 buffer0 wraps with both units", v, 16'h0100);
        rd(5, v); check("R8 buffer1 wraps", v, 16'h0200);
    endtask

    task automatic t_mod();
        logic [15:0] a0, a1, v;
        wr(4'd3, 16'h0101);
        go(3'd3, 3, 16'd10, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R9 large add step", v, 16'h0103);
        go(3'd4, 3, 16'd7, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R9 large subtract step", v, 16'h0100);
        go(3'd3, 3, 16'd4, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R9 step of full length", v, 16'h0100);
    endtask

    task automatic t_linear();
        logic [15:0] a0, a1, v;
        wr(4'd6, 16'h0103);
        go(3'd1, 6, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(6, v); check("R10 unbound pointer linear", v, 16'h0104);
        wr(4'd12, 16'h00B6);
        wr(4'd3, 16'h0103);
        go(3'd1, 3, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R10 disabled buffer linear", v, 16'h0104);
        wr(4'd12, 16'h00B7);
        wr(4'd3, 16'h0300);
        go(3'd1, 3, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R11 outside buffer linear", v, 16'h0301);
        wr(4'd9, 16'h00F0);
        wr(4'd3, 16'h0100);
        go(3'd3, 3, 16'h50, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R11 reversed bounds linear", v, 16'h0150);
        wr(4'd9, 16'h0103);
        wr(4'd12, 16'h0077);
        wr(4'd3, 16'h0103);
        go(3'd1, 3, 0, 3'd0, 0, 0, 0, 0, 0, a0, a1);
        rd(3, v); check("R10 buffer0 has priority", v, 16'h0100);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write();
        t_ops();
        t_dual();
        t_conflict();
        t_circ();
        t_mod();
        t_linear();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

endmodule